// File: doc/BRIEF.md
# Four-Channel Register-Programmed Copy Engine

This block moves data from one place in memory to another on behalf of a processor. Software sets it up through a narrow word-wide control register port. Each channel has a source address, a destination address, an element count and a control word. The write to the control word that sets the enable bit is also the command that starts the copy. Every channel also holds a chaining address pair. The chaining address is stored and can be read back, but it does not affect the copy.

One shared mover handles one element at a time over a simple request/response memory master port. For each element it issues a read of 1, 2, 4 or 8 bytes and waits for the returned data. It then issues a write of the same size. After each element the source and destination addresses each either step forward by one element or stay where they are. When a channel's last element has been written, the channel's busy flag drops and its bit in a shared status word is set. Software clears that status bit by writing a one to it. If more than one channel is waiting, the lowest-numbered channel runs first.

Top module: `dmax_engine`

## Requirements
- R1: After reset every register offset reads zero, `dma_busy` is all zero and no memory request is raised.
- R2: Channel c owns offsets c*8 to c*8+7, in this order: control, count, source high, source low, destination high, destination low, chain high, chain low. Every one of these reads back what was last written to it. A write to one 32-bit half of a 64-bit address leaves the other half unchanged.
- R3: Offsets above 0x20 read zero, and writes to them change no register and no status bit.
- R4: A control write with bit 31 set starts a transfer only if the low 16 bits of the count register are nonzero. When it starts one, `dma_busy[c]` is high from the next clock edge. When the count is zero, no memory request is made and busy stays low, but the control value is still stored.
- R5: The element width in bytes is 1 << ctrl[26:25]. `mem_req_size` carries that 2-bit code. Element bytes sit in little-endian order in the low bytes of the read and write data. Bytes beyond the element in the read data are dropped and are driven as zero in the write data.
- R6: When ctrl[23] is set, the source address advances by one element width after each element, and when it is clear the source address stays fixed. ctrl[24] does the same for the destination address.
- R7: For each element the engine makes exactly one read request, waits for `mem_rsp_valid`, and then makes exactly one write request. A request holds its valid, address and direction until `mem_req_ready` is seen.
- R8: `dma_busy[c]` drops at the clock edge where the last write is accepted, and status bit c is set at the same edge. A control write to a busy channel is ignored.
- R9: The status word at offset 0x20 has bit c for channel c. Writing to it clears each bit that is set in the written value.
- R10: When several channels are busy, the mover runs the lowest-numbered one to completion before starting the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcr_wr | input | 1 | Register write strobe, one cycle |
| dcr_rd | input | 1 | Register read strobe, one cycle |
| dcr_addr | input | DCR_AW | Register offset |
| dcr_wdata | input | 32 | Register write data |
| dcr_rdata | output | 32 | Read data, registered, valid the cycle after `dcr_rd` |
| dma_busy | output | NCH | Per-channel transfer in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | MEM_AW | Byte address |
| mem_req_size | output | 2 | Element width code, 1 << size bytes |
| mem_req_wdata | output | 64 | Write data, little-endian in the low bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Read data, little-endian in the low bytes |

## Verification
The properties assume that the memory side returns exactly one `mem_rsp_valid` pulse for each accepted read, and only while that read is outstanding. They also assume `dcr_rd` and `dcr_wr` are never both high. `mem_req_ready` may drop at any cycle. The bench memory model follows these rules: a pending-read flag gates its response, and the response delay comes from a shift-register pattern. The same pattern toggles `mem_req_ready`, so every hold and ordering rule is exercised under back-pressure. Register accesses come from two tasks that raise only one strobe at a time.

// File: rtl/dmax_pkg.sv
package dmax_pkg;

   // control word bit positions (software-visible encoding)
   localparam int CTRL_EN_BIT   = 31;
   localparam int CTRL_WID_LSB  = 25;
   localparam int CTRL_DINC_BIT = 24;
   localparam int CTRL_SINC_BIT = 23;

   // per-channel register index within an 8-word slot
   localparam int RIX_CTRL   = 0;
   localparam int RIX_COUNT  = 1;
   localparam int RIX_SRC_HI = 2;
   localparam int RIX_SRC_LO = 3;
   localparam int RIX_DST_HI = 4;
   localparam int RIX_DST_LO = 5;
   localparam int RIX_CHN_HI = 6;
   localparam int RIX_CHN_LO = 7;

   localparam int STATUS_OFF = 32;

   typedef enum logic [1:0] {
      MV_IDLE,
      MV_RD,
      MV_RWAIT,
      MV_WR
   } mv_state_t;

   typedef struct packed {
      logic [1:0] wcode;
      logic       src_inc;
      logic       dst_inc;
   } xfer_mode_t;

   function automatic logic [63:0] lane_mask(input logic [1:0] code);
      logic [63:0] m;
      case (code)
         2'd0:    m = 64'h0000_0000_0000_00FF;
         2'd1:    m = 64'h0000_0000_0000_FFFF;
         2'd2:    m = 64'h0000_0000_FFFF_FFFF;
         default: m = 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
      return m;
   endfunction

   function automatic logic [63:0] elem_bytes(input logic [1:0] code);
      return 64'(1) << code;
   endfunction

endpackage

// File: rtl/dmax_chan.sv
module dmax_chan
   import dmax_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       reg_idx,
   input  logic [31:0]      wdata,
   input  logic             done,
   output logic [31:0]      rword,
   output logic             busy,
   output logic [63:0]      src,
   output logic [63:0]      dst,
   output xfer_mode_t       mode,
   output logic [CNT_W-1:0] count
);

   logic [31:0] ctrl_q;
   logic [31:0] cnt_q;
   logic [63:0] src_q;
   logic [63:0] dst_q;
   logic [63:0] chn_q;
   logic        busy_q;
   logic        launch;

   assign launch = wr_en && (reg_idx == 3'(RIX_CTRL)) && wdata[CTRL_EN_BIT]
                   && (cnt_q[CNT_W-1:0] != '0) && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         chn_q  <= '0;
      end else if (wr_en) begin
         case (reg_idx)
            3'(RIX_CTRL):   if (!busy_q) ctrl_q <= wdata;
            3'(RIX_COUNT):  cnt_q <= wdata;
            3'(RIX_SRC_HI): src_q[63:32] <= wdata;
            3'(RIX_SRC_LO): src_q[31:0]  <= wdata;
            3'(RIX_DST_HI): dst_q[63:32] <= wdata;
            3'(RIX_DST_LO): dst_q[31:0]  <= wdata;
            3'(RIX_CHN_HI): chn_q[63:32] <= wdata;
            default:        chn_q[31:0]  <= wdata;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (done)   busy_q <= 1'b0;
      else if (launch) busy_q <= 1'b1;
   end

   always_comb begin
      case (reg_idx)
         3'(RIX_CTRL):   rword = ctrl_q;
         3'(RIX_COUNT):  rword = cnt_q;
         3'(RIX_SRC_HI): rword = src_q[63:32];
         3'(RIX_SRC_LO): rword = src_q[31:0];
         3'(RIX_DST_HI): rword = dst_q[63:32];
         3'(RIX_DST_LO): rword = dst_q[31:0];
         3'(RIX_CHN_HI): rword = chn_q[63:32];
         default:        rword = chn_q[31:0];
      endcase
   end

   assign busy         = busy_q;
   assign src          = src_q;
   assign dst          = dst_q;
   assign count        = cnt_q[CNT_W-1:0];
   assign mode.wcode   = ctrl_q[CTRL_WID_LSB+1:CTRL_WID_LSB];
   assign mode.src_inc = ctrl_q[CTRL_SINC_BIT];
   assign mode.dst_inc = ctrl_q[CTRL_DINC_BIT];

endmodule

// File: rtl/dmax_regif.sv
module dmax_regif
   import dmax_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DCR_AW = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dcr_wr,
   input  logic                  dcr_rd,
   input  logic [DCR_AW-1:0]     dcr_addr,
   input  logic [31:0]           dcr_wdata,
   output logic [31:0]           dcr_rdata,
   output logic [NCH-1:0]        ch_wr_en,
   output logic [2:0]            reg_idx,
   input  logic [NCH-1:0][31:0]  ch_rwords,
   input  logic [NCH-1:0]        done_vec
);

   localparam int CHAN_SPAN = NCH * 8;

   logic             hit_chan;
   logic             hit_stat;
   logic [2:0]       ch_sel;
   logic [NCH-1:0]   status_q;
   logic [NCH-1:0]   clr_mask;
   logic [31:0]      rd_next;

   assign hit_chan = dcr_addr < DCR_AW'(CHAN_SPAN);
   assign hit_stat = dcr_addr == DCR_AW'(STATUS_OFF);
   assign ch_sel   = dcr_addr[5:3];
   assign reg_idx  = dcr_addr[2:0];

   for (genvar g = 0; g < NCH; g++) begin : g_wen
      assign ch_wr_en[g] = dcr_wr && hit_chan && (ch_sel == 3'(g));
   end

   always_comb begin
      rd_next = '0;
      if (hit_chan) begin
         for (int i = 0; i < NCH; i++) begin
            if (ch_sel == 3'(i)) rd_next = ch_rwords[i];
         end
      end else if (hit_stat) begin
         rd_next = 32'(status_q);
      end
   end

   assign clr_mask = (dcr_wr && hit_stat) ? dcr_wdata[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (status_q & ~clr_mask) | done_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dcr_rdata <= '0;
      else if (dcr_rd) dcr_rdata <= rd_next;
   end

endmodule

// File: rtl/dmax_mover.sv
module dmax_mover
   import dmax_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int CNT_W  = 16,
   parameter int MEM_AW = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCH-1:0]              busy_vec,
   input  logic [NCH-1:0][63:0]        src_all,
   input  logic [NCH-1:0][63:0]        dst_all,
   input  xfer_mode_t [NCH-1:0]        mode_all,
   input  logic [NCH-1:0][CNT_W-1:0]   cnt_all,
   output logic [NCH-1:0]              done_vec,
   output logic                        mem_req_valid,
   input  logic                        mem_req_ready,
   output logic                        mem_req_we,
   output logic [MEM_AW-1:0]           mem_req_addr,
   output logic [1:0]                  mem_req_size,
   output logic [63:0]                 mem_req_wdata,
   input  logic                        mem_rsp_valid,
   input  logic [63:0]                 mem_rsp_rdata
);

   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   mv_state_t        state_q;
   logic [CH_W-1:0]  cur_ch_q;
   logic [CH_W-1:0]  pick;
   logic [63:0]      src_q;
   logic [63:0]      dst_q;
   logic [CNT_W-1:0] remain_q;
   xfer_mode_t       mode_q;
   logic [63:0]      data_q;
   logic [63:0]      step;
   logic [63:0]      addr_full;
   logic             wr_accept;
   logic             last_elem;

   // lowest-numbered waiting channel wins
   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (busy_vec[i]) pick = CH_W'(i);
      end
   end

   assign step      = elem_bytes(mode_q.wcode);
   assign wr_accept = (state_q == MV_WR) && mem_req_ready;
   assign last_elem = remain_q == CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= MV_IDLE;
         cur_ch_q <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         remain_q <= '0;
         mode_q   <= '0;
         data_q   <= '0;
      end else begin
         case (state_q)
            MV_IDLE: begin
               if (|busy_vec) begin
                  cur_ch_q <= pick;
                  src_q    <= src_all[pick];
                  dst_q    <= dst_all[pick];
                  mode_q   <= mode_all[pick];
                  remain_q <= cnt_all[pick];
                  state_q  <= MV_RD;
               end
            end
            MV_RD: begin
               if (mem_req_ready) state_q <= MV_RWAIT;
            end
            MV_RWAIT: begin
               if (mem_rsp_valid) begin
                  data_q  <= mem_rsp_rdata & lane_mask(mode_q.wcode);
                  state_q <= MV_WR;
               end
            end
            default: begin
               if (mem_req_ready) begin
                  if (mode_q.src_inc) src_q <= src_q + step;
                  if (mode_q.dst_inc) dst_q <= dst_q + step;
                  remain_q <= remain_q - CNT_W'(1);
                  state_q  <= last_elem ? MV_IDLE : MV_RD;
               end
            end
         endcase
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_done
      assign done_vec[g] = wr_accept && last_elem && (cur_ch_q == CH_W'(g));
   end

   assign addr_full     = (state_q == MV_WR) ? dst_q : src_q;
   assign mem_req_valid = (state_q == MV_RD) || (state_q == MV_WR);
   assign mem_req_we    = state_q == MV_WR;
   assign mem_req_size  = mode_q.wcode;
   assign mem_req_wdata = data_q;

   if (MEM_AW == 64) begin : g_addr_full
      assign mem_req_addr = addr_full;
   end else begin : g_addr_trunc
      logic [63-MEM_AW:0] addr_hi_unused;
      assign mem_req_addr   = addr_full[MEM_AW-1:0];
      assign addr_hi_unused = addr_full[63:MEM_AW];
   end

endmodule

// File: rtl/dmax_engine.sv
module dmax_engine
   import dmax_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DCR_AW = 10,
   parameter int CNT_W  = 16,
   parameter int MEM_AW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dcr_wr,
   input  logic              dcr_rd,
   input  logic [DCR_AW-1:0] dcr_addr,
   input  logic [31:0]       dcr_wdata,
   output logic [31:0]       dcr_rdata,
   output logic [NCH-1:0]    dma_busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [MEM_AW-1:0] mem_req_addr,
   output logic [1:0]        mem_req_size,
   output logic [63:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [63:0]       mem_rsp_rdata
);

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("dmax_engine: NCH must be 1..4 so channels fit below the status word");
   end
   if (DCR_AW < 6) begin : g_bad_aw
      $error("dmax_engine: DCR_AW must cover offsets up to 0x3F");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("dmax_engine: CNT_W must be 1..32");
   end
   if (MEM_AW < 12 || MEM_AW > 64) begin : g_bad_maw
      $error("dmax_engine: MEM_AW must be 12..64");
   end

   logic [NCH-1:0]             ch_wr_en;
   logic [2:0]                 reg_idx;
   logic [NCH-1:0][31:0]       ch_rwords;
   logic [NCH-1:0]             done_vec;
   logic [NCH-1:0][63:0]       src_all;
   logic [NCH-1:0][63:0]       dst_all;
   xfer_mode_t [NCH-1:0]       mode_all;
   logic [NCH-1:0][CNT_W-1:0]  cnt_all;

   dmax_regif #(
      .NCH    (NCH),
      .DCR_AW (DCR_AW)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .dcr_wr    (dcr_wr),
      .dcr_rd    (dcr_rd),
      .dcr_addr  (dcr_addr),
      .dcr_wdata (dcr_wdata),
      .dcr_rdata (dcr_rdata),
      .ch_wr_en  (ch_wr_en),
      .reg_idx   (reg_idx),
      .ch_rwords (ch_rwords),
      .done_vec  (done_vec)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dmax_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (ch_wr_en[g]),
         .reg_idx (reg_idx),
         .wdata   (dcr_wdata),
         .done    (done_vec[g]),
         .rword   (ch_rwords[g]),
         .busy    (dma_busy[g]),
         .src     (src_all[g]),
         .dst     (dst_all[g]),
         .mode    (mode_all[g]),
         .count   (cnt_all[g])
      );
   end

   dmax_mover #(
      .NCH    (NCH),
      .CNT_W  (CNT_W),
      .MEM_AW (MEM_AW)
   ) u_mover (
      .clk           (clk),
      .rst_n         (rst_n),
      .busy_vec      (dma_busy),
      .src_all       (src_all),
      .dst_all       (dst_all),
      .mode_all      (mode_all),
      .cnt_all       (cnt_all),
      .done_vec      (done_vec),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_we    (mem_req_we),
      .mem_req_addr  (mem_req_addr),
      .mem_req_size  (mem_req_size),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata)
   );

endmodule

// File: rtl/dmax_engine_chk.sv
module dmax_engine_chk
   import dmax_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DCR_AW = 10,
   parameter int MEM_AW = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    dma_busy,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_we,
   input logic [MEM_AW-1:0] mem_req_addr,
   input logic [1:0]        mem_req_size,
   input logic [63:0]       mem_req_wdata,
   input logic              mem_rsp_valid,
   input logic              dcr_rd,
   input logic [DCR_AW-1:0] dcr_addr,
   input logic [31:0]       dcr_rdata
);

   logic [NCH-1:0] busy_prev;
   logic           rsp_seen;
   logic           wr_hs;
   logic           busy_fell;

   assign wr_hs     = mem_req_valid && mem_req_ready && mem_req_we;
   assign busy_fell = |(busy_prev & ~dma_busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_prev <= '0;
         rsp_seen  <= 1'b0;
      end else begin
         busy_prev <= dma_busy;
         if (mem_rsp_valid) rsp_seen <= 1'b1;
         else if (wr_hs)    rsp_seen <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr))); // R7

   AST_WR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we) |-> rsp_seen); // R7

   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_busy == '0) |-> !mem_req_valid); // R4

   AST_NARROW_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we) |->
         ((mem_req_wdata & ~lane_mask(mem_req_size)) == 64'd0)); // R5

   AST_BUSY_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_fell |-> $past(wr_hs)); // R8

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (dcr_rd && (dcr_addr > DCR_AW'(STATUS_OFF))) |=> (dcr_rdata == 32'd0)); // R3

endmodule

bind dmax_engine dmax_engine_chk #(
   .NCH    (NCH),
   .DCR_AW (DCR_AW),
   .MEM_AW (MEM_AW)
) u_chk (.*);

// File: tb/sim_dmax_engine.sv
`timescale 1ns/1ps
module sim_dmax_engine;

   localparam int NCH    = 4;
   localparam int DCR_AW = 10;
   localparam int MEM_AW = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dcr_wr = 1'b0;
   logic              dcr_rd = 1'b0;
   logic [DCR_AW-1:0] dcr_addr = '0;
   logic [31:0]       dcr_wdata = '0;
   logic [31:0]       dcr_rdata;
   logic [NCH-1:0]    dma_busy;
   logic              mem_req_valid;
   logic              mem_req_ready;
   logic              mem_req_we;
   logic [MEM_AW-1:0] mem_req_addr;
   logic [1:0]        mem_req_size;
   logic [63:0]       mem_req_wdata;
   logic              mem_rsp_valid = 1'b0;
   logic [63:0]       mem_rsp_rdata = '0;

   always #2 clk = ~clk;

   dmax_engine #(.NCH(NCH), .DCR_AW(DCR_AW), .MEM_AW(MEM_AW)) u0 (.*);

   // ---------------- memory model ----------------
   logic [7:0]  mem [0:4095] = '{default: 8'h00};
   logic [15:0] lfsr = 16'hACE1;
   logic        rd_pend = 1'b0;
   logic [63:0] rd_word = '0;
   logic        pl_en = 1'b0;
   logic [11:0] pl_addr = '0;
   logic [7:0]  pl_data = '0;
   int          nreads = 0;
   int          nwrites = 0;
   int          proto_err = 0;
   logic        rd_open = 1'b0;

   assign mem_req_ready = lfsr[0] | lfsr[4];

   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pl_en) mem[pl_addr] <= pl_data;
      mem_rsp_valid <= 1'b0;
      if (rd_pend && lfsr[3]) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_rdata <= rd_word;
         rd_pend       <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            for (int b = 0; b < 8; b++)
               if (b < (1 << mem_req_size))
                  mem[mem_req_addr[11:0] + 12'(b)] <= mem_req_wdata[8*b +: 8];
            if (!rd_open) proto_err <= proto_err + 1;
            rd_open <= 1'b0;
            nwrites <= nwrites + 1;
         end else begin
            for (int b = 0; b < 8; b++)
               rd_word[8*b +: 8] <= mem[mem_req_addr[11:0] + 12'(b)];
            rd_pend <= 1'b1;
            if (rd_open) proto_err <= proto_err + 1;
            rd_open <= 1'b1;
            nreads  <= nreads + 1;
         end
      end
   end

   // order in which channels finish
   logic [NCH-1:0] busy_prev = '0;
   int             done_log [0:15];
   int             done_n = 0;
   always @(posedge clk) begin
      busy_prev <= dma_busy;
      for (int c = 0; c < NCH; c++) begin
         if (busy_prev[c] && !dma_busy[c] && done_n < 16) begin
            done_log[done_n] <= c;
            done_n <= done_n + 1;
         end
      end
   end

   // ---------------- bench bookkeeping ----------------
   int nchecks = 0;
   int nfail   = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic dcr_w(input int addr, input logic [31:0] data);
      dcr_wr = 1'b1; dcr_addr = DCR_AW'(addr); dcr_wdata = data;
      @(negedge clk);
      dcr_wr = 1'b0;
   endtask

   task automatic dcr_r(input int addr, output logic [31:0] data);
      dcr_rd = 1'b1; dcr_addr = DCR_AW'(addr);
      @(negedge clk);
      dcr_rd = 1'b0;
      data = dcr_rdata;
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   task automatic preload();
      for (int i = 0; i < 32; i++) begin
         pl_en = 1'b1; pl_addr = 12'(256 + i); pl_data = pat(i);
         @(negedge clk);
      end
      pl_en = 1'b0;
   endtask

   task automatic prog(input int ch, input int src, input int dst, input logic [31:0] cnt);
      dcr_w(ch*8 + 2, 32'h0);
      dcr_w(ch*8 + 3, 32'(src));
      dcr_w(ch*8 + 4, 32'h0);
      dcr_w(ch*8 + 5, 32'(dst));
      dcr_w(ch*8 + 1, cnt);
   endtask

   task automatic wait_idle(input logic [NCH-1:0] mask);
      for (int i = 0; i < 5000; i++) begin
         if ((dma_busy & mask) == '0) break;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] ctrl_word(input int wcode, input bit sinc, input bit dinc);
      return 32'h8000_0000 | (32'(wcode) << 25) | (32'(dinc) << 24) | (32'(sinc) << 23);
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] v;
      int bad = 0;
      chk(dma_busy == '0, "R1 busy after reset", 64'(dma_busy), 0);
      chk(!mem_req_valid, "R1 no request after reset", 64'(mem_req_valid), 0);
      for (int a = 0; a < 64; a++) begin
         dcr_r(a, v);
         if (v != 0) bad++;
      end
      chk(bad == 0, "R1 registers zero after reset", 64'(bad), 0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      for (int c = 0; c < NCH; c++)
         for (int x = 0; x < 8; x++)
            dcr_w(c*8 + x, 32'h1234_0000 | 32'(c*16 + x));
      for (int c = 0; c < NCH; c++)
         for (int x = 0; x < 8; x++) begin
            dcr_r(c*8 + x, v);
            chk(v == (32'h1234_0000 | 32'(c*16 + x)), "R2 readback", 64'(v), 64'(32'h1234_0000 | 32'(c*16 + x)));
         end
      dcr_w(3, 32'hDEAD_0000);
      dcr_r(2, v);
      chk(v == 32'h1234_0002, "R2 high half kept on low write", 64'(v), 64'h1234_0002);
      dcr_r(3, v);
      chk(v == 32'hDEAD_0000, "R2 low half replaced", 64'(v), 64'hDEAD_0000);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      int bad = 0;
      for (int a = 33; a < 64; a++) dcr_w(a, 32'hFFFF_FFFF);
      dcr_w(1023, 32'hFFFF_FFFF);
      for (int a = 33; a < 64; a++) begin
         dcr_r(a, v);
         if (v != 0) bad++;
      end
      dcr_r(1023, v);
      if (v != 0) bad++;
      chk(bad == 0, "R3 unmapped offsets read zero", 64'(bad), 0);
      dcr_r(0, v);
      chk(v == 32'h1234_0000, "R3 channel reg untouched", 64'(v), 64'h1234_0000);
      dcr_r(32, v);
      chk(v == 0, "R3 status untouched", 64'(v), 0);
      chk(dma_busy == '0 && nreads == 0, "R3 no transfer from unmapped writes", 64'(nreads), 0);
   endtask

   task automatic t_zero_count();
      logic [31:0] v;
      int r0 = nreads;
      prog(1, 256, 1280, 32'h0001_0000);
      dcr_w(8, ctrl_word(0, 1, 1));
      chk(dma_busy[1] == 1'b0, "R4 zero count no busy", 64'(dma_busy), 0);
      tick(8);
      chk(nreads == r0 && dma_busy == '0, "R4 zero count no memory traffic", 64'(nreads - r0), 0);
      dcr_r(8, v);
      chk(v == ctrl_word(0, 1, 1), "R4 control stored on zero count", 64'(v), 64'(ctrl_word(0, 1, 1)));
   endtask

   task automatic t_copy_inc();
      logic [31:0] v;
      int bad = 0;
      int r0 = nreads, w0 = nwrites;
      prog(0, 256, 1024, 32'd3);
      dcr_w(0, ctrl_word(2, 1, 1));
      chk(dma_busy[0] == 1'b1, "R4 busy after launch", 64'(dma_busy), 1);
      wait_idle(4'b0001);
      for (int i = 0; i < 12; i++) if (mem[1024 + i] != pat(i)) bad++;
      chk(bad == 0, "R6 4-byte incrementing copy", 64'(bad), 0);
      chk(mem[1036] == 8'h00, "R5 no byte past transfer", 64'(mem[1036]), 0);
      chk(nreads - r0 == 3 && nwrites - w0 == 3, "R7 one read and one write per element",
          64'(nreads - r0), 3);
      dcr_r(32, v);
      chk(v == 32'h1, "R8 status bit set on completion", 64'(v), 1);
   endtask

   task automatic t_widths();
      int bad;
      // 1-byte elements
      prog(1, 256, 1280, 32'd5);
      dcr_w(8, ctrl_word(0, 1, 1));
      wait_idle(4'b0010);
      bad = 0;
      for (int i = 0; i < 5; i++) if (mem[1280 + i] != pat(i)) bad++;
      chk(bad == 0 && mem[1285] == 8'h00, "R5 width 1 copy", 64'(bad), 0);
      // 2-byte elements
      prog(1, 256, 1536, 32'd3);
      dcr_w(8, ctrl_word(1, 1, 1));
      wait_idle(4'b0010);
      bad = 0;
      for (int i = 0; i < 6; i++) if (mem[1536 + i] != pat(i)) bad++;
      chk(bad == 0 && mem[1542] == 8'h00, "R5 width 2 copy", 64'(bad), 0);
      // 8-byte elements
      prog(1, 256, 1792, 32'd2);
      dcr_w(8, ctrl_word(3, 1, 1));
      wait_idle(4'b0010);
      bad = 0;
      for (int i = 0; i < 16; i++) if (mem[1792 + i] != pat(i)) bad++;
      chk(bad == 0 && mem[1808] == 8'h00, "R5 width 8 copy", 64'(bad), 0);
   endtask

   task automatic t_fixed();
      int bad = 0;
      prog(2, 258, 2048, 32'd4);
      dcr_w(16, ctrl_word(1, 0, 1));
      wait_idle(4'b0100);
      for (int k = 0; k < 4; k++)
         if (mem[2048 + 2*k] != pat(2) || mem[2049 + 2*k] != pat(3)) bad++;
      chk(bad == 0, "R6 fixed source repeats element", 64'(bad), 0);
      prog(3, 256, 2304, 32'd3);
      dcr_w(24, ctrl_word(0, 1, 0));
      wait_idle(4'b1000);
      chk(mem[2304] == pat(2), "R6 fixed destination holds last element", 64'(mem[2304]), 64'(pat(2)));
      chk(mem[2305] == 8'h00, "R6 fixed destination does not advance", 64'(mem[2305]), 0);
   endtask

   task automatic t_busy_priority();
      logic [31:0] v;
      int base;
      prog(1, 256, 2816, 32'd2);
      prog(3, 256, 3072, 32'd2);
      prog(2, 256, 2560, 32'd20);
      base = done_n;
      dcr_w(16, ctrl_word(0, 1, 1));
      dcr_w(16, 32'h0);
      dcr_r(16, v);
      chk(v == ctrl_word(0, 1, 1), "R8 control write to busy channel ignored", 64'(v), 64'(ctrl_word(0, 1, 1)));
      dcr_w(24, ctrl_word(0, 1, 1));
      dcr_w(8, ctrl_word(0, 1, 1));
      chk(dma_busy == 4'b1110, "R4 three channels pending", 64'(dma_busy), 64'hE);
      wait_idle(4'b1111);
      tick(2);
      chk(done_n - base == 3 && done_log[base] == 2 && done_log[base+1] == 1 && done_log[base+2] == 3,
          "R10 lowest pending channel served next",
          64'(done_log[base+1]), 1);
      chk(mem[2560 + 19] == pat(19) && mem[2816 + 1] == pat(1) && mem[3072 + 1] == pat(1),
          "R10 all queued copies complete", 64'(mem[2579]), 64'(pat(19)));
   endtask

   task automatic t_status();
      logic [31:0] v;
      dcr_r(32, v);
      chk(v == 32'hF, "R9 all status bits set", 64'(v), 64'hF);
      dcr_w(32, 32'h5);
      dcr_r(32, v);
      chk(v == 32'hA, "R9 write ones clears only those bits", 64'(v), 64'hA);
      dcr_w(32, 32'hFFFF_FFFF);
      dcr_r(32, v);
      chk(v == 32'h0, "R9 status fully cleared", 64'(v), 0);
      chk(proto_err == 0, "R7 read and write alternate", 64'(proto_err), 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_regmap();
      t_unmapped();
      preload();
      t_zero_count();
      t_copy_inc();
      t_widths();
      t_fixed();
      t_busy_priority();
      t_status();
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

endmodule